// File: doc/BRIEF.md
# I/O Port Write Permission Unit

This block takes one port-output request at a time from a simple processor front end and turns it into a single write on a memory-mapped I/O window, or into a general-protection fault. It works out the access width from the opcode and the operand-size attribute. It takes the port number either from an 8-bit immediate or from a 16-bit register input. It then decides whether the privilege rules call for a look at the per-port permission bitmap.

When the bitmap has to be consulted, the unit reads it one bit per cycle through a synchronous read port. It reads one bit for each byte the access touches. Any set bit stops the scan and faults the request. An access whose later bytes would run past port 65535 also faults.

A permitted request is mapped into a paged window above a programmable base, with four ports per 4 KB page. It faults if data translation is off or if the address lies outside the implemented virtual range. Otherwise the write waits until the count of outstanding older memory operations reaches zero. While a request is in flight, a stall output holds back younger memory operations.

Top module: `ioport_write_guard`

## Requirements
- R1: The access width comes from opcode bit 0 and the operand-size input. With bit 0 clear the access is one byte. With bit 0 set it is two bytes when `req_opsize32` is 0 and four bytes when it is 1. `wr_be` is the width mask (0001, 0011 or 1111) shifted left by port bits [1:0], keeping only the four lane bits. `wr_data` is the data masked to the width and shifted left by 8 times port bits [1:0].
- R2: With opcode bit 3 set, the port number is `req_dx`. With bit 3 clear, it is `req_imm` with the upper 8 bits zero, and `req_dx` has no effect.
- R3: A bitmap check is needed when `prot_en` is 1 and either `v86_mode` is 1 or `priv_cpl` is greater than `priv_iopl`. When no check is needed, or when `perm_map_en` is 0, no bitmap read is issued. In that case the outcome (write or fault) appears in the cycle after the first clock edge that follows the accepting edge.
- R4: During a check, the unit reads bitmap addresses port, port+1, and so on in ascending order, one per cycle, up to the access width. A bit read back as 1 stops the scan and faults the request; it does not write. A set bit at position j shows `fault` 3+j edges after the accepting edge. When all bits are clear, the write path is entered n+2 edges after it, where n is the width in bytes.
- R5: During a check, an access whose next byte would lie past port 65535 faults at that point, and that read is never issued. A one-byte access to port 65535 is allowed.
- R6: The write address is `io_base` OR (port bits [15:2] shifted left by 12) OR port bits [11:0].
- R7: After the permission decision, the request faults instead of writing if `xlat_en` was 0 or if any address bit at or above VA_BITS is 1.
- R8: `wr_strobe` is asserted only in a cycle where `pend_mem_ops` is zero. A permitted write waits as long as the count is nonzero.
- R9: `req_ready` is 1 only when no request is in flight, so only one request is handled at a time. `younger_stall` is 1 from the accepting edge until the request retires.
- R10: `fault` and `done` are single-cycle pulses. `done` is asserted together with either `wr_strobe` or `fault`, never with both. The request, base and flags are sampled at the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit idle, request accepted this cycle if valid |
| req_opcode | input | 8 | Output opcode; bit 0 selects wide access, bit 3 selects register port |
| req_opsize32 | input | 1 | Operand-size attribute: 1 = four bytes, 0 = two bytes |
| req_imm | input | 8 | Immediate port number |
| req_dx | input | 16 | Register port number |
| req_data | input | 32 | Data to write, low-aligned |
| prot_en | input | 1 | Protected mode on |
| v86_mode | input | 1 | Virtual-8086 mode on |
| priv_cpl | input | 2 | Current privilege level |
| priv_iopl | input | 2 | I/O privilege level |
| perm_map_en | input | 1 | Enables the bitmap check |
| xlat_en | input | 1 | Data translation enabled |
| io_base | input | BASE_W | Window base address |
| pend_mem_ops | input | PEND_W | Count of outstanding older memory operations |
| bm_rd_en | output | 1 | Bitmap read request |
| bm_rd_addr | output | 16 | Bitmap bit index (port number) |
| bm_rd_bit | input | 1 | Bitmap bit, valid the cycle after the read |
| younger_stall | output | 1 | Hold younger memory operations |
| wr_strobe | output | 1 | Window write strobe |
| wr_addr | output | BASE_W | Window write address |
| wr_be | output | 4 | Byte-lane enables |
| wr_data | output | 32 | Lane-aligned write data |
| fault | output | 1 | General-protection fault pulse |
| done | output | 1 | Request retired pulse |

## Verification
A scan counter that is off by one shows up in two ways at the ports. The bitmap addresses read back would not match port+k, or `fault`/`done` would land a cycle early or late against the 3+j and n+2 timing; both are seen within one cycle of the error. A wrong width or port-source decode shows up in `wr_be`, `wr_data` or `wr_addr` on the strobe cycle, or in a read of the wrong bitmap bit. A state machine that leaves its idle state wrongly shows at once in `req_ready` and `younger_stall`, which the bench compares on every cycle of every request.

// File: rtl/iopw_pkg.sv
package iopw_pkg;

    localparam int PORT_W = 16;
    localparam int LANES  = 4;
    localparam int DATA_W = 8 * LANES;
    localparam int CNT_W  = 3;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2
    } port_size_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_DECIDE = 3'd1,
        ST_SCAN   = 3'd2,
        ST_DRAIN  = 3'd3,
        ST_FAULT  = 3'd4
    } iopw_state_e;

    typedef struct packed {
        logic [PORT_W-1:0] port;
        port_size_e        size;
        logic [DATA_W-1:0] data;
        logic              scan;
    } io_req_t;

    function automatic logic [CNT_W-1:0] size_bytes(port_size_e s);
        case (s)
            SZ_BYTE:  return CNT_W'(1);
            SZ_WORD:  return CNT_W'(2);
            default:  return CNT_W'(4);
        endcase
    endfunction

    function automatic logic [LANES-1:0] size_mask(port_size_e s);
        case (s)
            SZ_BYTE:  return LANES'(4'b0001);
            SZ_WORD:  return LANES'(4'b0011);
            default:  return LANES'(4'b1111);
        endcase
    endfunction

endpackage

// File: rtl/iopw_decode.sv
module iopw_decode import iopw_pkg::*; (
    input  logic              op_wide,
    input  logic              op_dx,
    input  logic              opsize32,
    input  logic [7:0]        imm,
    input  logic [PORT_W-1:0] dx,
    input  logic [DATA_W-1:0] data,
    input  logic              prot_en,
    input  logic              v86_mode,
    input  logic [1:0]        cpl,
    input  logic [1:0]        iopl,
    input  logic              map_en,
    output io_req_t           req
);
    logic need_check;

    // Privilege test: protected mode with either V86 or an under-privileged caller
    assign need_check = prot_en && (v86_mode || (cpl > iopl));

    always_comb begin
        req.port = op_dx ? dx : {{(PORT_W-8){1'b0}}, imm};
        if (!op_wide)
            req.size = SZ_BYTE;
        else
            req.size = opsize32 ? SZ_DWORD : SZ_WORD;
        req.data = data;
        req.scan = need_check && map_en;
    end
endmodule

// File: rtl/iopw_bitmap_scan.sv
module iopw_bitmap_scan import iopw_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic [PORT_W-1:0] port,
    input  logic [CNT_W-1:0]  nbytes,
    input  logic              bm_bit,
    output logic              rd_en,
    output logic [PORT_W-1:0] rd_addr,
    output logic              pass,
    output logic              deny
);
    logic [CNT_W-1:0] issued;
    logic [CNT_W-1:0] checked;
    logic             bit_vld;
    logic [PORT_W:0]  next_idx;
    logic             hit;
    logic             last_clear;
    logic             more;
    logic             wraps;

    assign next_idx   = {1'b0, port} + (PORT_W+1)'(issued);
    assign hit        = bit_vld && bm_bit;
    assign last_clear = bit_vld && !bm_bit && (CNT_W'(checked + CNT_W'(1)) == nbytes);
    assign more       = issued < nbytes;
    assign wraps      = next_idx[PORT_W];

    // Reads are pipelined: bit k is judged while bit k+1 is requested
    assign rd_en   = active && !hit && !last_clear && more && !wraps;
    assign rd_addr = next_idx[PORT_W-1:0];
    assign pass    = active && last_clear;
    assign deny    = active && (hit || (!last_clear && more && wraps));

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            issued  <= '0;
            checked <= '0;
            bit_vld <= 1'b0;
        end else begin
            bit_vld <= rd_en;
            if (rd_en)
                issued <= issued + CNT_W'(1);
            if (bit_vld)
                checked <= checked + CNT_W'(1);
        end
    end
endmodule

// File: rtl/iopw_window.sv
module iopw_window import iopw_pkg::*; #(
    parameter int BASE_W  = 64,
    parameter int VA_BITS = 51
) (
    input  logic [BASE_W-1:0] base,
    input  logic [PORT_W-1:0] port,
    input  port_size_e        size,
    input  logic [DATA_W-1:0] data,
    input  logic              xlat_en,
    output logic [BASE_W-1:0] addr,
    output logic [LANES-1:0]  be,
    output logic [DATA_W-1:0] wdata,
    output logic              xlat_bad
);
    localparam int PAGE_SHIFT = 12;

    logic [2*LANES-1:0]  be_wide;
    logic [DATA_W-1:0]   byte_mask;
    logic [LANES-1:0]    lanes;
    logic                out_of_range;

    assign lanes   = size_mask(size);
    assign addr    = base
                   | (BASE_W'(port[PORT_W-1:2]) << PAGE_SHIFT)
                   | BASE_W'(port[PAGE_SHIFT-1:0]);
    assign be_wide = {{LANES{1'b0}}, lanes} << port[1:0];
    assign be      = be_wide[LANES-1:0];

    for (genvar g = 0; g < LANES; g++) begin : g_mask
        assign byte_mask[8*g +: 8] = {8{lanes[g]}};
    end

    assign wdata = (data & byte_mask) << {port[1:0], 3'b000};

    if (VA_BITS < BASE_W) begin : g_range
        assign out_of_range = |addr[BASE_W-1:VA_BITS];
    end else begin : g_full
        assign out_of_range = 1'b0;
    end

    assign xlat_bad = !xlat_en || out_of_range;
endmodule

// File: rtl/ioport_write_guard.sv
module ioport_write_guard import iopw_pkg::*; #(
    parameter int BASE_W  = 64,
    parameter int VA_BITS = 51,
    parameter int PEND_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [7:0]        req_opcode,
    input  logic              req_opsize32,
    input  logic [7:0]        req_imm,
    input  logic [15:0]       req_dx,
    input  logic [31:0]       req_data,
    input  logic              prot_en,
    input  logic              v86_mode,
    input  logic [1:0]        priv_cpl,
    input  logic [1:0]        priv_iopl,
    input  logic              perm_map_en,
    input  logic              xlat_en,
    input  logic [BASE_W-1:0] io_base,
    input  logic [PEND_W-1:0] pend_mem_ops,
    output logic              bm_rd_en,
    output logic [15:0]       bm_rd_addr,
    input  logic              bm_rd_bit,
    output logic              younger_stall,
    output logic              wr_strobe,
    output logic [BASE_W-1:0] wr_addr,
    output logic [3:0]        wr_be,
    output logic [31:0]       wr_data,
    output logic              fault,
    output logic              done
);
    iopw_state_e       state, state_nx;
    io_req_t           dec_req, cur;
    logic [BASE_W-1:0] cur_base;
    logic              cur_xlat;
    logic              accept;
    logic              scan_pass, scan_deny, xlat_bad, drained;
    logic              unused_opcode_bits;

    assign unused_opcode_bits = ^{req_opcode[7:4], req_opcode[2:1]};

    iopw_decode u_decode (
        .op_wide  (req_opcode[0]),
        .op_dx    (req_opcode[3]),
        .opsize32 (req_opsize32),
        .imm      (req_imm),
        .dx       (req_dx),
        .data     (req_data),
        .prot_en  (prot_en),
        .v86_mode (v86_mode),
        .cpl      (priv_cpl),
        .iopl     (priv_iopl),
        .map_en   (perm_map_en),
        .req      (dec_req)
    );

    iopw_bitmap_scan u_scan (
        .clk     (clk),
        .rst     (rst),
        .active  (state == ST_SCAN),
        .port    (cur.port),
        .nbytes  (size_bytes(cur.size)),
        .bm_bit  (bm_rd_bit),
        .rd_en   (bm_rd_en),
        .rd_addr (bm_rd_addr),
        .pass    (scan_pass),
        .deny    (scan_deny)
    );

    iopw_window #(.BASE_W(BASE_W), .VA_BITS(VA_BITS)) u_window (
        .base     (cur_base),
        .port     (cur.port),
        .size     (cur.size),
        .data     (cur.data),
        .xlat_en  (cur_xlat),
        .addr     (wr_addr),
        .be       (wr_be),
        .wdata    (wr_data),
        .xlat_bad (xlat_bad)
    );

    assign accept  = req_valid && (state == ST_IDLE);
    assign drained = (pend_mem_ops == '0);

    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE:   if (accept) state_nx = ST_DECIDE;
            ST_DECIDE: begin
                if (cur.scan)      state_nx = ST_SCAN;
                else if (xlat_bad) state_nx = ST_FAULT;
                else               state_nx = ST_DRAIN;
            end
            ST_SCAN: begin
                if (scan_deny)      state_nx = ST_FAULT;
                else if (scan_pass) state_nx = xlat_bad ? ST_FAULT : ST_DRAIN;
            end
            ST_DRAIN:  if (drained) state_nx = ST_IDLE;
            ST_FAULT:  state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cur      <= '0;
            cur_base <= '0;
            cur_xlat <= 1'b0;
        end else begin
            state <= state_nx;
            if (accept) begin
                cur      <= dec_req;
                cur_base <= io_base;
                cur_xlat <= xlat_en;
            end
        end
    end

    assign req_ready     = (state == ST_IDLE);
    assign younger_stall = (state != ST_IDLE);
    assign wr_strobe     = (state == ST_DRAIN) && drained;
    assign fault         = (state == ST_FAULT);
    assign done          = wr_strobe || fault;
endmodule

// File: rtl/iopw_checker.sv
module iopw_checker #(
    parameter int PEND_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              fault,
    input logic              done,
    input logic              wr_strobe,
    input logic [3:0]        wr_be,
    input logic              bm_rd_en,
    input logic [PEND_W-1:0] pend_mem_ops,
    input logic              younger_stall
);
    a_r8_drain_before_write: assert property (@(posedge clk) disable iff (rst)
        wr_strobe |-> (pend_mem_ops == '0));

    a_r10_fault_pulse: assert property (@(posedge clk) disable iff (rst)
        fault |=> !fault);

    a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r10_one_outcome: assert property (@(posedge clk) disable iff (rst)
        done |-> (fault ^ wr_strobe));

    a_r10_outcome_retires: assert property (@(posedge clk) disable iff (rst)
        (fault || wr_strobe) |-> done);

    a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (!req_ready && younger_stall));

    a_r9_idle_after_retire: assert property (@(posedge clk) disable iff (rst)
        done |=> req_ready);

    a_r4_read_only_in_flight: assert property (@(posedge clk) disable iff (rst)
        bm_rd_en |-> (!req_ready && !done));

    a_r1_lanes_on_write: assert property (@(posedge clk) disable iff (rst)
        wr_strobe |-> (wr_be != 4'b0000));
endmodule

bind ioport_write_guard iopw_checker #(.PEND_W(PEND_W)) u_iopw_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .fault         (fault),
    .done          (done),
    .wr_strobe     (wr_strobe),
    .wr_be         (wr_be),
    .bm_rd_en      (bm_rd_en),
    .pend_mem_ops  (pend_mem_ops),
    .younger_stall (younger_stall)
);

// File: tb/tb_ioport_write_guard.sv
module tb_ioport_write_guard;
    localparam int BASE_W  = 64;
    localparam int VA_BITS = 51;
    localparam int PEND_W  = 6;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [7:0]        req_opcode = '0;
    logic              req_opsize32 = 1'b0;
    logic [7:0]        req_imm = '0;
    logic [15:0]       req_dx = '0;
    logic [31:0]       req_data = '0;
    logic              prot_en = 1'b0;
    logic              v86_mode = 1'b0;
    logic [1:0]        priv_cpl = '0;
    logic [1:0]        priv_iopl = '0;
    logic              perm_map_en = 1'b0;
    logic              xlat_en = 1'b1;
    logic [BASE_W-1:0] io_base = '0;
    logic [PEND_W-1:0] pend_mem_ops = '0;
    logic              bm_rd_en;
    logic [15:0]       bm_rd_addr;
    logic              bm_rd_bit = 1'b0;
    logic              younger_stall;
    logic              wr_strobe;
    logic [BASE_W-1:0] wr_addr;
    logic [3:0]        wr_be;
    logic [31:0]       wr_data;
    logic              fault;
    logic              done;

    int vectors = 0;
    int miscompares = 0;
    int cyc = 0;
    int deny_q[$];

    ioport_write_guard #(.BASE_W(BASE_W), .VA_BITS(VA_BITS), .PEND_W(PEND_W)) dut (.*);

    function automatic bit is_denied(int a);
        foreach (deny_q[i]) if (deny_q[i] == a) return 1'b1;
        return 1'b0;
    endfunction

    // Bitmap store model: synchronous single-bit read
    always @(posedge clk) bm_rd_bit <= bm_rd_en && is_denied(int'(bm_rd_addr));

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            miscompares++;
            $display("FAIL watchdog: run hung, cycle %0d expected below 100000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic run(input string tag, input logic [7:0] op, input logic sz32,
                       input logic [7:0] imm, input logic [15:0] dx, input logic [31:0] data,
                       input logic pe, input logic vm, input logic [1:0] cp, input logic [1:0] ip,
                       input logic ce, input logic xe, input logic [63:0] base, input int rel);
        int n, lp, lf, ls, lend, reads_exp, reads_got;
        logic scan, flt;
        logic [15:0] port;
        logic [3:0]  msk, be_e;
        logic [7:0]  be_w;
        logic [31:0] d_e;
        logic [63:0] a_e;
        port = op[3] ? dx : {8'h00, imm};
        n    = !op[0] ? 1 : (sz32 ? 4 : 2);
        msk  = (n == 1) ? 4'h1 : ((n == 2) ? 4'h3 : 4'hF);
        be_w = {4'h0, msk} << port[1:0];
        be_e = be_w[3:0];
        d_e  = (data & {{8{msk[3]}}, {8{msk[2]}}, {8{msk[1]}}, {8{msk[0]}}}) << (8 * port[1:0]);
        a_e  = base | (64'(port[15:2]) << 12) | 64'(port[11:0]);
        scan = pe && (vm || (cp > ip)) && ce;
        flt = 1'b0; lp = 1; lf = -1; ls = -1; reads_exp = 0;
        if (scan) begin
            for (int j = 0; j < n; j++) begin
                if (is_denied(int'(port) + j)) begin
                    flt = 1'b1; lf = 3 + j; reads_exp = j + 1; break;
                end
                if (j == n - 1) begin
                    lp = n + 2; reads_exp = n;
                end else if (int'(port) + j + 1 > 65535) begin
                    flt = 1'b1; lf = 3 + j; reads_exp = j + 1; break;
                end
            end
        end
        if (!flt && (!xe || ((a_e >> VA_BITS) != 64'd0))) begin
            flt = 1'b1; lf = lp;
        end
        if (!flt) ls = (rel > lp) ? rel : lp;
        lend = flt ? lf : ls;

        @(negedge clk);
        req_valid = 1'b1; req_opcode = op; req_opsize32 = sz32; req_imm = imm; req_dx = dx;
        req_data = data; prot_en = pe; v86_mode = vm; priv_cpl = cp; priv_iopl = ip;
        perm_map_en = ce; xlat_en = xe; io_base = base;
        pend_mem_ops = (rel > 0) ? PEND_W'(4) : '0;
        @(posedge clk);
        reads_got = 0;
        for (int i = 0; i <= lend + 1; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
            if (i == rel) pend_mem_ops = '0;
            #5;
            vectors++;
            if (fault !== (flt && i == lf) || wr_strobe !== (!flt && i == ls) ||
                done !== (i == lend) || req_ready !== (i > lend) || younger_stall !== (i <= lend)) begin
                miscompares++;
                $display("FAIL %s step %0d: fault/strobe/done/ready/stall = %b%b%b%b%b expected %b%b%b%b%b",
                         tag, i, fault, wr_strobe, done, req_ready, younger_stall,
                         flt && i == lf, !flt && i == ls, i == lend, i > lend, i <= lend);
            end
            if (bm_rd_en) begin
                vectors++;
                if (bm_rd_addr !== 16'(int'(port) + reads_got)) begin
                    miscompares++;
                    $display("FAIL %s bitmap read %0d: addr %h expected %h", tag, reads_got,
                             bm_rd_addr, 16'(int'(port) + reads_got));
                end
                reads_got++;
            end
            if (wr_strobe) begin
                vectors++;
                if (wr_addr !== a_e || wr_be !== be_e || wr_data !== d_e) begin
                    miscompares++;
                    $display("FAIL %s write: addr %h be %b data %h expected %h %b %h",
                             tag, wr_addr, wr_be, wr_data, a_e, be_e, d_e);
                end
            end
        end
        vectors++;
        if (reads_got != reads_exp) begin
            miscompares++;
            $display("FAIL %s bitmap read count: %0d expected %0d", tag, reads_got, reads_exp);
        end
    endtask

    localparam logic [63:0] B0 = 64'h0000_1000_0000_0000;

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #5;
        vectors++;
        if (req_ready !== 1'b1 || fault !== 1'b0 || wr_strobe !== 1'b0 || done !== 1'b0 ||
            bm_rd_en !== 1'b0 || younger_stall !== 1'b0) begin
            miscompares++;
            $display("FAIL R9 reset: ready/fault/strobe/done/rd/stall = %b%b%b%b%b%b expected 100000",
                     req_ready, fault, wr_strobe, done, bm_rd_en, younger_stall);
        end

        // R1, R2, R6: decode and window mapping without checks
        run("R2_imm_byte",   8'hE6, 1'b0, 8'h41, 16'h0000, 32'hDEAD_BE5A, 0, 0, 2'd0, 2'd0, 0, 1, B0, 0);
        run("R2_dx_byte",    8'hEE, 1'b0, 8'h00, 16'hABCD, 32'h1234_5677, 0, 0, 2'd0, 2'd0, 0, 1, B0, 0);
        run("R1_word",       8'hEF, 1'b0, 8'h00, 16'h1236, 32'hCAFE_F00D, 0, 0, 2'd0, 2'd0, 0, 1, B0, 0);
        run("R1_dword",      8'hEF, 1'b1, 8'h00, 16'h2000, 32'h8765_4321, 0, 0, 2'd0, 2'd0, 0, 1, B0, 0);
        run("R2_imm_ignores_dx", 8'hE7, 1'b0, 8'h80, 16'hBEEF, 32'h0000_A5C3, 0, 0, 2'd0, 2'd0, 0, 1, B0, 0);
        run("R6_high_port",  8'hEF, 1'b1, 8'h00, 16'hF7F4, 32'h0BAD_CAFE, 0, 0, 2'd0, 2'd0, 0, 1, 64'h0000_0002_0000_0000, 0);

        // R3: check-free paths
        run("R3_map_off",    8'hEF, 1'b0, 8'h00, 16'h0300, 32'h1111_2222, 1, 0, 2'd3, 2'd0, 0, 1, B0, 0);
        run("R3_privileged", 8'hEF, 1'b0, 8'h00, 16'h0300, 32'h3333_4444, 1, 0, 2'd0, 2'd3, 1, 1, B0, 0);
        run("R3_real_mode",  8'hEE, 1'b0, 8'h00, 16'h0300, 32'h5555_6666, 0, 1, 2'd3, 2'd0, 1, 1, B0, 0);

        // R4: bitmap scan
        deny_q = {};
        run("R4_scan_clear", 8'hEF, 1'b0, 8'h00, 16'h0300, 32'h7777_8888, 1, 0, 2'd3, 2'd0, 1, 1, B0, 0);
        deny_q = {32'h0402};
        run("R4_deny_third", 8'hEF, 1'b1, 8'h00, 16'h0400, 32'h9999_AAAA, 1, 1, 2'd0, 2'd3, 1, 1, B0, 0);
        deny_q = {32'h0050};
        run("R4_deny_first", 8'hE7, 1'b1, 8'h50, 16'h0000, 32'hBBBB_CCCC, 1, 0, 2'd2, 2'd1, 1, 1, B0, 0);
        deny_q = {32'h0403};
        run("R4_deny_past",  8'hEF, 1'b0, 8'h00, 16'h0400, 32'hDDDD_EEEE, 1, 0, 2'd3, 2'd0, 1, 1, B0, 0);
        deny_q = {};

        // R5: top-of-space crossing
        run("R5_word_cross", 8'hEF, 1'b0, 8'h00, 16'hFFFF, 32'h0102_0304, 1, 0, 2'd3, 2'd0, 1, 1, B0, 0);
        run("R5_dword_cross",8'hEF, 1'b1, 8'h00, 16'hFFFE, 32'h0506_0708, 1, 0, 2'd3, 2'd0, 1, 1, B0, 0);
        run("R5_byte_top",   8'hEE, 1'b0, 8'h00, 16'hFFFF, 32'h0000_00E1, 1, 0, 2'd3, 2'd0, 1, 1, B0, 0);

        // R7: translation faults
        run("R7_xlat_off",   8'hE6, 1'b0, 8'h10, 16'h0000, 32'h0000_0042, 0, 0, 2'd0, 2'd0, 0, 0, B0, 0);
        run("R7_unimpl",     8'hE6, 1'b0, 8'h10, 16'h0000, 32'h0000_0042, 0, 0, 2'd0, 2'd0, 0, 1, 64'h1000_0000_0000_0000, 0);
        run("R7_after_scan", 8'hEF, 1'b1, 8'h00, 16'h0600, 32'h4242_4242, 1, 0, 2'd3, 2'd0, 1, 0, B0, 0);

        // R8: drain behind older memory operations
        run("R8_drain_wait", 8'hEF, 1'b0, 8'h00, 16'h0700, 32'hABCD_1234, 0, 0, 2'd0, 2'd0, 0, 1, B0, 6);
        run("R8_drain_scan", 8'hEF, 1'b1, 8'h00, 16'h0800, 32'h1357_9BDF, 1, 0, 2'd3, 2'd0, 1, 1, B0, 9);

        // R9, R10: back-to-back requests keep pulses single and handshake clean
        run("R10_back1",     8'hE6, 1'b0, 8'h03, 16'h0000, 32'h0000_00AA, 0, 0, 2'd0, 2'd0, 0, 1, B0, 0);
        run("R9_back2",      8'hE6, 1'b0, 8'h04, 16'h0000, 32'h0000_00BB, 0, 0, 2'd0, 2'd0, 0, 0, B0, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule